// File: doc/BRIEF.md
# Snapshot Match Timer

This peripheral keeps a free-running 64-bit tick count behind a programmable prescaler and exposes it on a simple 32-bit register bus. The count cannot be read as one word. Software writes a capture command, and the whole count is copied in one clock into a pair of snapshot registers. Software then reads the two halves at leisure and the result is always coherent. Software may also write either half of the count directly. That write is held back and takes effect on the next prescaler tick.

Six 32-bit compare channels watch the low word of the count. A channel hits on the increment that makes the low word equal to its value. A hit sets a sticky flag, and an enabled flag drives a level interrupt. Channel 5 doubles as a watchdog: when its arm bit is set, a hit also produces a one-cycle reset request.

Top module: `snap_timer`

## Requirements
- R1: After reset the status flags, interrupt enables, watchdog arm bit, divider, match values and snapshot words read 0, and both `irq` and `wdog_rst` are low.
- R2: Registers sit at these byte offsets: 0x00 count low, 0x04 count high, 0x08 + 4*i match i (i = 0..5), 0x20 status, 0x24 interrupt enable, 0x28 watchdog arm (bit 0), 0x2C divider, 0x30 capture (bit 0), 0x34 snapshot low, 0x38 snapshot high. `bus_rdata` is valid one cycle after `bus_rd`. Offsets that are not mapped read 0.
- R3: With divider value D the count advances once every 2*(D+1) clock cycles.
- R4: Writing the divider restarts the prescaler phase, so the next advance comes a full 2*(D+1) cycles after that write.
- R5: A write to either count word does not show at once. It replaces that word on the next prescaler tick, and that tick does not also increment the count.
- R6: Writing 1 to bit 0 of the capture register copies the full 64-bit count, as it stands in that cycle, into the snapshot words. The snapshot keeps that value until the next capture.
- R7: A channel sets status bit i when an increment makes the low count word equal to match i. The high word takes no part in the compare.
- R8: A match value equal to a count that is not moving never sets the flag.
- R9: Status bits are write-one-to-clear. Writing 0 to a bit leaves it alone, and a hit in the same cycle as a clear wins.
- R10: `irq` is a level. It equals the OR over i of (status[i] AND enable[i]), registered once, so it follows a change of status or enable by one cycle.
- R11: When the watchdog arm bit is set, a channel 5 hit raises `wdog_rst` for exactly one cycle, in the same cycle that status bit 5 is set. When the arm bit is clear, the hit sets only the flag.
- R12: The count carries from the low word into the high word, so 0x1_FFFFFFFF advances to 0x2_00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
A prescaler phase that goes wrong shows up as a wrong difference between two snapshots taken a fixed number of cycles apart. The same fault appears as an advance that comes before or after the 2*(D+1) boundary that follows a divider write. These errors surface within one prescaler period. A bad pending-load or carry path leaves a wrong snapshot value one tick after the load. A wrong flag or compare path shows in the status readback and on `irq` one cycle later. A fault in the watchdog gating shows as too many or too few `wdog_rst` pulses in the window of a channel 5 hit.

// File: rtl/snap_tmr_pkg.sv
package snap_tmr_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] A_CNT_LO = 6'h00;
  localparam logic [REG_AW-1:0] A_CNT_HI = 6'h04;
  localparam logic [REG_AW-1:0] A_MATCH0 = 6'h08;
  localparam logic [REG_AW-1:0] A_STATUS = 6'h20;
  localparam logic [REG_AW-1:0] A_IEN    = 6'h24;
  localparam logic [REG_AW-1:0] A_WDEN   = 6'h28;
  localparam logic [REG_AW-1:0] A_DIV    = 6'h2C;
  localparam logic [REG_AW-1:0] A_CAPT   = 6'h30;
  localparam logic [REG_AW-1:0] A_SNAP_LO = 6'h34;
  localparam logic [REG_AW-1:0] A_SNAP_HI = 6'h38;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             div_wr,
  output logic             tick
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] lim;

  // period 2*(div+1) => terminal count 2*div+1
  assign lim  = {div, 1'b1};
  assign tick = (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || div_wr) pcnt <= '0;
    else if (tick)     pcnt <= '0;
    else               pcnt <= pcnt + PC_W'(1);
  end

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst) pcnt <= lim);
  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst) div_wr |=> pcnt == '0);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] cnt,
  output logic          inc_evt
);
  localparam int CW = 2 * DW;

  logic          pend_lo, pend_hi;
  logic [DW-1:0] pval_lo, pval_hi;

  assign inc_evt = tick && !(pend_lo || pend_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pend_lo <= 1'b0;
      pend_hi <= 1'b0;
      pval_lo <= '0;
      pval_hi <= '0;
    end else begin
      if (tick) begin
        if (pend_lo || pend_hi) begin
          cnt     <= {pend_hi ? pval_hi : cnt[CW-1:DW], pend_lo ? pval_lo : cnt[DW-1:0]};
          pend_lo <= 1'b0;
          pend_hi <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      // a write in a tick cycle stays pending for the following tick
      if (wr_lo) begin
        pend_lo <= 1'b1;
        pval_lo <= wdata;
      end
      if (wr_hi) begin
        pend_hi <= 1'b1;
        pval_hi <= wdata;
      end
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc_evt |=> cnt == $past(cnt) + CW'(1));
  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic                   inc_evt,
  input  logic [DW-1:0]          next_lo,
  input  logic [NCH-1:0][DW-1:0] mval,
  output logic [NCH-1:0]         hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g] = inc_evt && (next_lo == mval[g]);
  end
endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_tmr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NCH     = 6,
  parameter int WDOG_CH = 5,
  parameter int DIV_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              wdog_rst
);
  localparam int CW = 2 * DW;

  logic [NCH-1:0][DW-1:0] mval;
  logic [NCH-1:0]         status, ien, hit, m_wr, clr;
  logic                   wden;
  logic [DIV_W-1:0]       div;
  logic [DW-1:0]          snap_lo, snap_hi;
  logic [CW-1:0]          cnt;
  logic                   tick, inc_evt;
  logic [DW-1:0]          rd_val;

  logic wr_lo, wr_hi, wr_stat, wr_ien, wr_wden, wr_div, capt;
  assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_stat = bus_wr && (bus_addr == A_STATUS);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign wr_wden = bus_wr && (bus_addr == A_WDEN);
  assign wr_div  = bus_wr && (bus_addr == A_DIV);
  assign capt    = bus_wr && (bus_addr == A_CAPT) && bus_wdata[0];

  for (genvar g = 0; g < NCH; g++) begin : g_mdec
    assign m_wr[g] = bus_wr && (bus_addr == A_MATCH0 + REG_AW'(4 * g));
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .div(div), .div_wr(wr_div), .tick(tick)
  );

  tmr_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .cnt(cnt), .inc_evt(inc_evt)
  );

  tmr_match #(.NCH(NCH), .DW(DW)) u_match (
    .inc_evt(inc_evt), .next_lo(cnt[DW-1:0] + DW'(1)), .mval(mval), .hit(hit)
  );

  assign clr = wr_stat ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mval     <= '0;
      status   <= '0;
      ien      <= '0;
      wden     <= 1'b0;
      div      <= '0;
      snap_lo  <= '0;
      snap_hi  <= '0;
      irq      <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (m_wr[i]) mval[i] <= bus_wdata;
      status <= (status & ~clr) | hit;
      if (wr_ien)  ien  <= bus_wdata[NCH-1:0];
      if (wr_wden) wden <= bus_wdata[0];
      if (wr_div)  div  <= bus_wdata[DIV_W-1:0];
      if (capt) begin
        snap_lo <= cnt[DW-1:0];
        snap_hi <= cnt[CW-1:DW];
      end
      irq      <= |(status & ien);
      wdog_rst <= wden && hit[WDOG_CH];
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_CNT_LO:  rd_val = cnt[DW-1:0];
      A_CNT_HI:  rd_val = cnt[CW-1:DW];
      A_STATUS:  rd_val = DW'(status);
      A_IEN:     rd_val = DW'(ien);
      A_WDEN:    rd_val = DW'(wden);
      A_DIV:     rd_val = DW'(div);
      A_SNAP_LO: rd_val = snap_lo;
      A_SNAP_HI: rd_val = snap_hi;
      default:   rd_val = '0;
    endcase
    for (int i = 0; i < NCH; i++)
      if (bus_addr == A_MATCH0 + REG_AW'(4 * i)) rd_val = mval[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R6
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    capt |=> {snap_hi, snap_lo} == $past(cnt));
  // R6
  snap_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !capt |=> $stable(snap_lo) && $stable(snap_hi));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & ien)));
  // R11
  wdog_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> status[WDOG_CH]);
  // R11
  wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst);
  for (genvar g = 0; g < NCH; g++) begin : g_schk
    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(status[g]) |-> $past(inc_evt));
  end
endmodule

// File: tb/snap_timer_bench.sv
module snap_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdog_rst;

  int checks = 0, errors = 0, wpulses = 0;

  always #10 clk = ~clk;

  snap_timer u_snap_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  always @(negedge clk) if (wdog_rst) wpulses++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 wdog_rst", wdog_rst, 0);
    rd(6'h20, d); chk("R1 status", d, 0);
    rd(6'h2C, d); chk("R1 divider", d, 0);
    rd(6'h34, d); chk("R1 snapshot low", d, 0);
    rd(6'h1C, d); chk("R1 match5", d, 0);
    rd(6'h3C, d); chk("R2 unmapped offset", d, 0);
  endtask

  task automatic t_rate(input logic [31:0] dv, input int win);
    logic [31:0] a, b;
    wr(6'h2C, dv);
    idle(5);
    wr(6'h30, 1); rd(6'h34, a);
    idle(win - 2);
    wr(6'h30, 1); rd(6'h34, b);
    chk("R3 advances per window", b - a, 10);
  endtask

  task automatic t_phase;
    logic [31:0] a, b, d;
    wr(6'h2C, 99);
    wr(6'h30, 1); rd(6'h34, a); rd(6'h38, d);
    idle(146);
    wr(6'h2C, 99);
    idle(99);
    wr(6'h30, 1); rd(6'h34, b);
    chk("R4 no advance before restarted period", b, a);
    idle(107);
    wr(6'h30, 1); rd(6'h34, b);
    chk("R4 advance after restarted period", b, a + 1);
    rd(6'h2C, d); chk("R2 divider readback", d, 99);
  endtask

  task automatic t_load;
    logic [31:0] lo, hi;
    wr(6'h2C, 99);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'h1);
    wr(6'h30, 1); rd(6'h38, hi);
    chk("R5 high write not yet visible", hi, 0);
    idle(297);
    wr(6'h30, 1); rd(6'h34, lo); rd(6'h38, hi);
    chk("R5 loaded value without increment", {hi, lo}, 64'h1_FFFF_FFFF);
    idle(200);
    wr(6'h30, 1); rd(6'h34, lo); rd(6'h38, hi);
    chk("R12 carry into high word", {hi, lo}, 64'h2_0000_0000);
    idle(300);
    rd(6'h34, lo); rd(6'h38, hi);
    chk("R6 snapshot held while count moves", {hi, lo}, 64'h2_0000_0000);
  endtask

  task automatic t_match;
    logic [31:0] d;
    wr(6'h20, 32'h3F);
    wr(6'h24, 32'h1);
    wr(6'h08, 104);
    wr(6'h10, 106);
    wr(6'h2C, 99);
    wr(6'h00, 100);
    wr(6'h04, 0);
    idle(250);
    rd(6'h20, d); chk("R7 no flag before match", d, 0);
    rd(6'h08, d); chk("R2 match0 readback", d, 104);
    wr(6'h2C, 0);
    idle(30);
    rd(6'h20, d); chk("R7 flags of channels 0 and 2", d, 32'h5);
    chk("R10 irq from enabled flag", irq, 1);
    wr(6'h20, 32'h1);
    idle(2);
    chk("R10 irq drops after clear", irq, 0);
    rd(6'h20, d); chk("R9 write-one clears only bit 0", d, 32'h4);
    wr(6'h24, 32'h4);
    idle(2);
    chk("R10 irq follows enable", irq, 1);
    wr(6'h24, 32'h0);
    idle(2);
    chk("R10 irq off with enable cleared", irq, 0);
  endtask

  task automatic t_retrig;
    logic [31:0] l, d;
    wr(6'h2C, 999);
    wr(6'h30, 1); rd(6'h34, l);
    wr(6'h0C, l);
    wr(6'h20, 32'h3F);
    idle(50);
    rd(6'h20, d); chk("R8 stationary equal count sets no flag", d, 0);
    wr(6'h0C, l + 3);
    wr(6'h2C, 0);
    idle(20);
    rd(6'h20, d); chk("R7 channel 1 hits when count moves", d, 32'h2);
  endtask

  task automatic t_wdog;
    logic [31:0] l, d;
    wr(6'h20, 32'h3F);
    wr(6'h28, 1);
    wr(6'h2C, 999);
    wr(6'h30, 1); rd(6'h34, l);
    wr(6'h1C, l + 5);
    wpulses = 0;
    wr(6'h2C, 0);
    idle(30);
    chk("R11 exactly one one-cycle pulse when armed", wpulses, 1);
    rd(6'h20, d); chk("R11 status bit 5 set", d, 32'h20);
    chk("R10 no irq with enables off", irq, 0);
    wr(6'h28, 0);
    wr(6'h2C, 999);
    wr(6'h30, 1); rd(6'h34, l);
    wr(6'h1C, l + 5);
    wr(6'h20, 32'h3F);
    wpulses = 0;
    wr(6'h2C, 0);
    idle(30);
    chk("R11 no pulse when disarmed", wpulses, 0);
    rd(6'h20, d); chk("R11 flag still set when disarmed", d, 32'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rate(0, 20);
    t_rate(3, 80);
    t_phase();
    t_load();
    t_match();
    t_retrig();
    t_wdog();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule